// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps a DDR SDRAM's contents alive by owing the array one auto-refresh per programmed interval and paying each debt with a REF command. The interval is given as a count of memory clock cycles, so the same hardware serves any clock frequency. A two-bit select shortens the period to one half, one quarter or one eighth of that count, which covers the 15.6, 7.8, 3.9 and 1.95 microsecond retention classes from a single base value. For example, a base of 3120 at 200 MHz is 15.6 microseconds.

A refresh goes out only when the bank timing logic reports that every bank is precharged. While banks stay busy, owed refreshes build up in a counter. Once too many are owed, the block asks the access scheduler to stall. After each REF, an active flag stays high for the full REF-to-REF recovery window (tRFC, which always exceeds the row cycle time) so that the access scheduler holds its own commands. A row pointer advances by one per REF and wraps at the end of the array.

The controller has three states. RFS_IDLE waits. It takes the transition "go" to RFS_ISSUE when at least one refresh is owed and the banks are idle. RFS_ISSUE lasts one cycle, drives the REF pulse, and takes the transition "arm" to RFS_RECOVER, where it loads the recovery timer. RFS_RECOVER counts the timer down and takes the transition "done" back to RFS_IDLE when the timer reaches zero.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and on the first cycle after it, ref_cmd, refresh_active and stall_req are 0, and ref_row and owed_count are 0.
- R2: The refresh period is P = base_interval >> interval_sel cycles. Select values 0, 1, 2 and 3 give the full, half, quarter and eighth period, and a result of 0 counts as 1. One refresh becomes owed every P cycles, and the first one is owed P cycles after reset.
- R3: ref_cmd is a one-cycle pulse. It occurs only in the cycle after a cycle in which banks_idle was 1, refresh_active was 0 and owed_count was nonzero. When all three held, it always occurs.
- R4: refresh_active is high for exactly max(trfc_cycles, 2) consecutive cycles, starting in the ref_cmd cycle. No ref_cmd occurs while it is high, and at least one inactive cycle follows before the next ref_cmd.
- R5: ref_row shows the row refreshed by the current ref_cmd. It advances by one in the cycle after each ref_cmd, wraps from 2^ROW_W-1 to 0, and otherwise holds.
- R6: owed_count rises by one per period and falls by one per ref_cmd. When both happen in the same cycle it is unchanged. It saturates at 2^W-1, where W = clog2(MAX_POSTPONE+1).
- R7: stall_req is 1 exactly while owed_count is at least MAX_POSTPONE (default 8).
- R8: When banks_idle returns after a backlog, the owed refreshes go out back to back, one every max(trfc_cycles, 2)+1 cycles.
- R9: banks_idle has no effect while nothing is owed: no ref_cmd occurs, and ref_row holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_interval | input | INTV_W | Refresh period in cycles for the longest interval class |
| interval_sel | input | 2 | Right shift applied to base_interval (0 to 3) |
| trfc_cycles | input | TRFC_W | REF-to-REF recovery window in cycles |
| banks_idle | input | 1 | All banks precharged, from the bank timing logic |
| ref_cmd | output | 1 | One-cycle REF command strobe |
| ref_row | output | ROW_W | Row targeted by the current refresh |
| refresh_active | output | 1 | Recovery window in progress; the access scheduler must hold commands |
| owed_count | output | clog2(MAX_POSTPONE+1) | Number of refreshes owed and not yet issued |
| stall_req | output | 1 | Backlog limit reached; accesses must stall |

## Verification
The bench holds the banks busy for long enough to drive the backlog past the stall threshold and into saturation. A counter that wrapped or released stall early would show a wrong owed_count and a missing stall_req. It then releases the banks and times the spacing of the drained REFs, which catches a recovery window that is off by one or a state machine that fires back to back. The interval select is switched while a period is already running, which exposes a timer that waits for an exact match and misses the shorter period. The row pointer is narrowed so that the bench sees it wrap. A run with nothing owed and the banks idle confirms that no spurious REF appears.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    typedef enum logic [1:0] {
        RFS_IDLE    = 2'd0,
        RFS_ISSUE   = 2'd1,
        RFS_RECOVER = 2'd2
    } rfs_state_t;
endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
    parameter int INTV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INTV_W-1:0] base_interval,
    input  logic [1:0]        interval_sel,
    output logic              tick
);
    logic [INTV_W-1:0] period;
    logic [INTV_W-1:0] cnt;

    always_comb begin
        period = base_interval >> interval_sel;
        if (period == '0) period = {{(INTV_W-1){1'b0}}, 1'b1};
    end

    // >= so a period shortened mid-count still fires at once
    assign tick = (cnt >= period - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || period == {{(INTV_W-1){1'b0}}, 1'b1}));  // R2
endmodule

// File: rtl/rfs_owed_ctr.sv
module rfs_owed_ctr #(
    parameter int MAX_POSTPONE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic [$clog2(MAX_POSTPONE+1)-1:0] owed,
    output logic stall
);
    localparam int OW_W = $clog2(MAX_POSTPONE+1);
    localparam logic [OW_W:0] SAT = {1'b0, {OW_W{1'b1}}};

    logic [OW_W:0] sum;

    always_comb begin
        sum = {1'b0, owed} + {{OW_W{1'b0}}, inc} - {{OW_W{1'b0}}, dec};
        if (sum > SAT) sum = SAT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) owed <= '0;
        else        owed <= sum[OW_W-1:0];
    end

    assign stall = ({1'b0, owed} >= (OW_W+1)'(MAX_POSTPONE));

    AST_OWED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !dec) |=> $stable(owed));  // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> owed != '0);  // R3
endmodule

// File: rtl/rfs_row_ctr.sv
module rfs_row_ctr #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] row
);
    // natural overflow gives the wrap from the last row to row 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    row <= '0;
        else if (step) row <= row + 1'b1;
    end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import rfs_pkg::*;
#(
    parameter int ROW_W        = 11,
    parameter int INTV_W       = 16,
    parameter int TRFC_W       = 8,
    parameter int MAX_POSTPONE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INTV_W-1:0] base_interval,
    input  logic [1:0]        interval_sel,
    input  logic [TRFC_W-1:0] trfc_cycles,
    input  logic              banks_idle,
    output logic              ref_cmd,
    output logic [ROW_W-1:0]  ref_row,
    output logic              refresh_active,
    output logic [$clog2(MAX_POSTPONE+1)-1:0] owed_count,
    output logic              stall_req
);
    localparam logic [TRFC_W-1:0] TWO = TRFC_W'(2);

    rfs_state_t        state, state_nx;
    logic [TRFC_W-1:0] rec_cnt;
    logic              tick;

    rfs_interval_timer #(.INTV_W(INTV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .base_interval(base_interval),
        .interval_sel(interval_sel), .tick(tick)
    );

    rfs_owed_ctr #(.MAX_POSTPONE(MAX_POSTPONE)) u_owed (
        .clk(clk), .rst_n(rst_n), .inc(tick), .dec(ref_cmd),
        .owed(owed_count), .stall(stall_req)
    );

    rfs_row_ctr #(.ROW_W(ROW_W)) u_row (
        .clk(clk), .rst_n(rst_n), .step(ref_cmd), .row(ref_row)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            RFS_IDLE:    if (owed_count != '0 && banks_idle) state_nx = RFS_ISSUE;
            RFS_ISSUE:   state_nx = RFS_RECOVER;
            RFS_RECOVER: if (rec_cnt == '0) state_nx = RFS_IDLE;
            default:     state_nx = RFS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RFS_IDLE;
        else        state <= state_nx;
    end

    // ISSUE counts as the first window cycle, so RECOVER runs trfc-1 cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   rec_cnt <= '0;
        else if (state == RFS_ISSUE)  rec_cnt <= (trfc_cycles < TWO) ? '0 : trfc_cycles - TWO;
        else if (rec_cnt != '0)       rec_cnt <= rec_cnt - 1'b1;
    end

    always_comb begin
        ref_cmd        = 1'b0;
        refresh_active = 1'b0;
        unique case (state)
            RFS_IDLE:    ;
            RFS_ISSUE:   begin ref_cmd = 1'b1; refresh_active = 1'b1; end
            RFS_RECOVER: refresh_active = 1'b1;
            default:     ;
        endcase
    end

    AST_REF_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |-> $past(banks_idle));  // R3
    AST_REF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |=> (!ref_cmd && refresh_active));  // R4
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |=> ref_row == $past(ref_row) + 1'b1);  // R5
    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_cmd |=> $stable(ref_row));  // R9
    AST_GAP_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(refresh_active) |-> !ref_cmd);  // R4
endmodule

// File: tb/dram_refresh_sched_tb_top.sv
module dram_refresh_sched_tb_top;
    localparam int ROW_W = 4, INTV_W = 16, TRFC_W = 8, MAXP = 8;
    localparam int OW_W  = $clog2(MAXP+1);
    localparam int SATV  = (1 << OW_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [INTV_W-1:0] base_interval = 16'd64;
    logic [1:0]        interval_sel  = 2'd3;
    logic [TRFC_W-1:0] trfc_cycles   = 8'd6;
    logic              banks_idle    = 1'b1;
    logic              ref_cmd, refresh_active, stall_req;
    logic [ROW_W-1:0]  ref_row;
    logic [OW_W-1:0]   owed_count;

    dram_refresh_sched #(.ROW_W(ROW_W), .INTV_W(INTV_W), .TRFC_W(TRFC_W), .MAX_POSTPONE(MAXP)) dut_i (
        .clk(clk), .rst_n(rst_n), .base_interval(base_interval), .interval_sel(interval_sel),
        .trfc_cycles(trfc_cycles), .banks_idle(banks_idle), .ref_cmd(ref_cmd), .ref_row(ref_row),
        .refresh_active(refresh_active), .owed_count(owed_count), .stall_req(stall_req)
    );

    int n_chk = 0, n_fail = 0;
    int m_cnt, m_debt, m_left, m_row;
    bit m_first;
    bit mon_en = 0, drain_mode = 0;
    int cyc = 0, last_ref = -1, ref_seen = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_debt = 0; m_left = 0; m_row = 0; m_first = 0;
        end else begin
            int p;
            bit tk, was_first;
            p = int'(base_interval) >> interval_sel;
            if (p == 0) p = 1;
            tk = (m_cnt >= p - 1);
            was_first = m_first;
            m_cnt = tk ? 0 : m_cnt + 1;
            if (m_left > 0) begin
                m_left--; m_first = 0;
            end else if (m_debt > 0 && banks_idle) begin
                m_left = (trfc_cycles < 2) ? 2 : int'(trfc_cycles); m_first = 1;
            end else m_first = 0;
            m_debt = m_debt + int'(tk) - int'(was_first);
            if (m_debt > SATV) m_debt = SATV;
            if (was_first) m_row = (m_row + 1) % (1 << ROW_W);
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (mon_en) begin
            chk(ref_cmd == m_first, "R3 ref_cmd", ref_cmd, m_first);
            chk(refresh_active == (m_left > 0), "R4 refresh_active", refresh_active, m_left > 0);
            chk(int'(ref_row) == m_row, "R5 ref_row", ref_row, m_row);
            chk(int'(owed_count) == m_debt, "R2 R6 owed_count", owed_count, m_debt);
            chk(stall_req == (m_debt >= MAXP), "R7 stall_req", stall_req, m_debt >= MAXP);
            if (ref_cmd) begin
                ref_seen++;
                if (drain_mode && last_ref >= 0)
                    chk(cyc - last_ref == int'(trfc_cycles) + 1, "R8 spacing", cyc - last_ref, int'(trfc_cycles) + 1);
                last_ref = cyc;
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        mon_en = 0; rst_n = 0;
        run(3);
        // R1: outputs in reset
        chk(ref_cmd == 0 && refresh_active == 0 && stall_req == 0, "R1 flags", {ref_cmd, refresh_active, stall_req}, 0);
        chk(ref_row == 0 && owed_count == 0, "R1 counters", {ref_row, owed_count}, 0);
        rst_n = 1;
        @(negedge clk);
        mon_en = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        // R2: each interval class in turn, banks always idle
        run(300);
        interval_sel = 2'd2; run(300);
        interval_sel = 2'd1; run(300);
        interval_sel = 2'd0; run(300);
        interval_sel = 2'd3; run(50);   // shortened mid-count

        // R9: nothing owed, banks idle, no REF expected
        base_interval = 16'hFFFF; interval_sel = 2'd0;
        do_reset();
        ref_seen = 0;
        run(300);
        chk(ref_seen == 0, "R9 no spurious REF", ref_seen, 0);
        chk(ref_row == 0, "R9 row held", ref_row, 0);

        // R6/R7: backlog builds to saturation
        base_interval = 16'd64; interval_sel = 2'd3; banks_idle = 0;
        do_reset();
        run(150);
        chk(int'(owed_count) == SATV, "R6 saturated", owed_count, SATV);
        chk(stall_req == 1, "R7 stall at limit", stall_req, 1);

        // R8: drain with a long period
        interval_sel = 2'd0; base_interval = 16'd2000;
        drain_mode = 1; last_ref = -1; banks_idle = 1;
        run(200);
        drain_mode = 0;
        chk(owed_count == 0, "R8 drained", owed_count, 0);
        chk(stall_req == 0, "R7 stall cleared", stall_req, 0);

        // R4: shortest and long recovery windows
        banks_idle = 0; run(30);
        trfc_cycles = 8'd1; base_interval = 16'd64; interval_sel = 2'd3;
        banks_idle = 1; run(300);
        banks_idle = 0; run(30);
        trfc_cycles = 8'd20; banks_idle = 1; run(400);
        banks_idle = 0; run(30);
        trfc_cycles = 8'd5;

        // mixed busy/idle traffic with interval changes
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            banks_idle = ($urandom % 4) != 0;
            if (k % 500 == 0) interval_sel = 2'($urandom % 4);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule